// File: doc/BRIEF.md
# Direct-Mapped Read Cache with Resumable Line Fill

This block is a read-only, direct-mapped cache placed between a requester and a slower next-level memory. Both sides talk through a word read port whose answer, within the same cycle, is one of three kinds: a data word, a miss that carries a stall-cycle count, or an invalid-address error. The number of sets, the number of 32-bit words per line and the fill latency are parameters.

A requester read that misses in an idle set opens a fill for that set. The fill first waits out the cache latency. It then pulls the line from the next level one word per cycle, starting at the line's first word. Each set keeps a pointer to the next word it still needs. A next-level stall therefore only pauses the fill: the countdown is reloaded with the stall count, and fetching picks up at the same word afterwards. While a fill is open, reads to that set get a miss response carrying the cycles left on the countdown, or the recorded error once one has occurred. A completed line is written into the set in a single step.

Top module: `dm_fill_cache`

## Requirements
- R1: An address splits, from least significant bit upward, into a byte offset of log2(4*LINE_WORDS) bits, a set index of log2(SETS) bits and a tag in the remaining bits. The word within the line is the byte offset divided by 4, so the two lowest address bits never change the word returned.
- R2: A read hits only when the set is valid and its stored tag equals the address tag. A hit answers in the same cycle with kind DATA (code 0) and the addressed word. A valid line holding a different tag answers MISS (code 1).
- R3: A read that misses on a set with no open fill answers MISS with stall equal to LATENCY and opens a fill for that line. With no contention, the first next-level request goes out LATENCY+1 cycles after the cycle of that read.
- R4: No next-level request is made for a fill while its countdown is nonzero. The countdown drops by one each cycle.
- R5: A fill requests the words of its line at line address plus 4 times its word pointer, in ascending order, and each word returned with DATA advances the pointer.
- R6: A next-level MISS carrying N reloads the countdown with N. When the countdown expires, fetching resumes at the same word, and no word that was already received is requested again.
- R7: A next-level ERR (code 2) is recorded in the fill and stops further fetching. The next requester read that misses on that set answers ERR and closes the fill, and a later read then opens a fresh fill.
- R8: When the last word of the line arrives, the line, its tag and the valid bit are written, and the fill closes. With no stall and no contention, the read LATENCY+LINE_WORDS+1 cycles after the opening read hits.
- R9: A read that misses on a set with an open fill and no recorded error answers MISS with the fill's remaining countdown.
- R10: Each set has at most one open fill. A read to that set for another tag answers MISS and opens no second fill, so the next level sees only the open fill's line.
- R11: Reset clears every valid bit and closes every fill, so the first read after reset answers MISS with stall LATENCY.
- R12: At most one next-level request is issued per cycle. Among the fills whose countdown is zero, the one in the lowest-numbered set is served first, and it takes over from a higher-numbered set even when that set's fill is already under way.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Requester read this cycle |
| req_addr | input | ADDR_W | Requester byte address |
| rsp_kind | output | 2 | Response kind: 0 data, 1 miss, 2 error (valid while req_valid) |
| rsp_data | output | 32 | Word returned on a hit |
| rsp_stall | output | STALL_W | Stall cycles reported with a miss |
| nl_req | output | 1 | Word request to the next level this cycle |
| nl_addr | output | ADDR_W | Word-aligned next-level address |
| nl_kind | input | 2 | Next-level answer kind, same encoding as rsp_kind |
| nl_data | input | 32 | Next-level data word |
| nl_stall | input | STALL_W | Next-level stall count on a miss |

## Verification
The bench targets the following corner cases:
- **Stall in the middle of a line.** The stall is injected on the third word. A design that restarts the fill shows extra requests for words it already holds, and its completion comes late.
- **Error path.** The bench checks the exact cycle of the error response and that the error reply closes the fill. A design that never closes it keeps answering ERR.
- **Two tags competing for one set.** These expose a design that opens a second fill or that hits on a stale tag.
- **Two fills whose countdowns overlap.** They must interleave in a fixed order: the lower-numbered set takes over the port after the higher one has received one word. A wrong priority or a word-pointer mix-up breaks that order.

Random reads with random stalls then compare every returned word against a computed memory image.

// File: rtl/dmc_pkg.sv
package dmc_pkg;

    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        RSP_DATA = 2'd0,
        RSP_MISS = 2'd1,
        RSP_ERR  = 2'd2
    } rsp_kind_e;

    // Lowest set bit of a request vector, returned as an index.
    function automatic int unsigned first_set(input logic [63:0] vec, input int unsigned n);
        int unsigned pick;
        pick = 0;
        for (int i = n - 1; i >= 0; i--) begin
            if (vec[i]) pick = i;
        end
        return pick;
    endfunction

endpackage

// File: rtl/dmc_set_fill.sv
module dmc_set_fill
    import dmc_pkg::*;
#(
    parameter int SET_ID     = 0,
    parameter int SETS       = 4,
    parameter int LINE_WORDS = 4,
    parameter int ADDR_W     = 32,
    parameter int STALL_W    = 8,
    parameter int LATENCY    = 3
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                open_i,
    input  logic [ADDR_W-$clog2(SETS)-$clog2(LINE_WORDS)-3:0] open_tag_i,
    input  logic                                close_i,
    input  logic                                grant_i,
    input  logic [1:0]                          nl_kind_i,
    input  logic [WORD_W-1:0]                   nl_data_i,
    input  logic [STALL_W-1:0]                  nl_stall_i,
    output logic                                busy_o,
    output logic                                ready_o,
    output logic                                err_o,
    output logic                                done_o,
    output logic [STALL_W-1:0]                  count_o,
    output logic [ADDR_W-1:0]                   fetch_addr_o,
    output logic [ADDR_W-$clog2(SETS)-$clog2(LINE_WORDS)-3:0] tag_o,
    output logic [LINE_WORDS-1:0][WORD_W-1:0]   line_o
);
    localparam int WSEL_W = $clog2(LINE_WORDS);
    localparam int IDX_W  = $clog2(SETS);
    localparam int TAG_W  = ADDR_W - IDX_W - WSEL_W - 2;
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(SET_ID);
    localparam logic [WSEL_W-1:0] LAST_W = WSEL_W'(LINE_WORDS - 1);

    logic                              busy_q;
    logic                              err_q;
    logic [STALL_W-1:0]                cnt_q;
    logic [WSEL_W-1:0]                 ptr_q;
    logic [TAG_W-1:0]                  tag_q;
    logic [LINE_WORDS-1:0][WORD_W-1:0] buf_q;
    logic                              fetch_now;

    assign fetch_now = busy_q && !err_q && (cnt_q == '0) && grant_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            err_q  <= 1'b0;
            cnt_q  <= '0;
            ptr_q  <= '0;
            tag_q  <= '0;
            buf_q  <= '0;
        end else if (open_i && !busy_q) begin
            busy_q <= 1'b1;
            err_q  <= 1'b0;
            cnt_q  <= STALL_W'(LATENCY);
            ptr_q  <= '0;
            tag_q  <= open_tag_i;
            buf_q  <= '0;
        end else if (busy_q) begin
            if (close_i && err_q) begin
                busy_q <= 1'b0;
            end else if (cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end else if (fetch_now) begin
                case (rsp_kind_e'(nl_kind_i))
                    RSP_DATA: begin
                        buf_q[ptr_q] <= nl_data_i;
                        if (ptr_q == LAST_W) begin
                            busy_q <= 1'b0;
                        end else begin
                            ptr_q <= ptr_q + 1'b1;
                        end
                    end
                    RSP_MISS: cnt_q <= nl_stall_i;
                    default:  err_q <= 1'b1;
                endcase
            end
        end
    end

    always_comb begin
        line_o             = buf_q;
        line_o[LINE_WORDS-1] = nl_data_i;
    end

    assign busy_o       = busy_q;
    assign err_o        = err_q;
    assign count_o      = cnt_q;
    assign tag_o        = tag_q;
    assign ready_o      = busy_q && !err_q && (cnt_q == '0);
    assign done_o       = fetch_now && (rsp_kind_e'(nl_kind_i) == RSP_DATA) && (ptr_q == LAST_W);
    assign fetch_addr_o = {tag_q, MY_IDX, ptr_q, 2'b00};

endmodule

// File: rtl/dmc_fetch_arb.sv
module dmc_fetch_arb
    import dmc_pkg::*;
#(
    parameter int SETS = 4
) (
    input  logic [SETS-1:0]         ready_i,
    output logic [SETS-1:0]         grant_o,
    output logic                    any_o,
    output logic [$clog2(SETS)-1:0] idx_o
);
    localparam int IDX_W = $clog2(SETS);

    logic [63:0] wide;

    always_comb begin
        wide          = '0;
        wide[SETS-1:0] = ready_i;
        idx_o         = IDX_W'(first_set(wide, SETS));
        any_o         = |ready_i;
        grant_o       = '0;
        if (any_o) grant_o[idx_o] = 1'b1;
    end

endmodule

// File: rtl/dmc_line_store.sv
module dmc_line_store
    import dmc_pkg::*;
#(
    parameter int SETS       = 4,
    parameter int LINE_WORDS = 4,
    parameter int TAG_W      = 26
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              wr_en_i,
    input  logic [$clog2(SETS)-1:0]           wr_idx_i,
    input  logic [TAG_W-1:0]                  wr_tag_i,
    input  logic [LINE_WORDS-1:0][WORD_W-1:0] wr_line_i,
    input  logic [$clog2(SETS)-1:0]           rd_idx_i,
    input  logic [TAG_W-1:0]                  rd_tag_i,
    input  logic [$clog2(LINE_WORDS)-1:0]     rd_word_i,
    output logic                              hit_o,
    output logic [WORD_W-1:0]                 rd_data_o,
    output logic [SETS-1:0]                   valid_o
);
    logic [SETS-1:0]                              valid_q;
    logic [SETS-1:0][TAG_W-1:0]                   tag_q;
    logic [SETS-1:0][LINE_WORDS-1:0][WORD_W-1:0]  data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else if (wr_en_i) begin
            valid_q[wr_idx_i] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en_i) begin
            tag_q[wr_idx_i]  <= wr_tag_i;
            data_q[wr_idx_i] <= wr_line_i;
        end
    end

    assign hit_o     = valid_q[rd_idx_i] && (tag_q[rd_idx_i] == rd_tag_i);
    assign rd_data_o = data_q[rd_idx_i][rd_word_i];
    assign valid_o   = valid_q;

endmodule

// File: rtl/dm_fill_cache.sv
module dm_fill_cache
    import dmc_pkg::*;
#(
    parameter int SETS       = 4,
    parameter int LINE_WORDS = 4,
    parameter int ADDR_W     = 32,
    parameter int STALL_W    = 8,
    parameter int LATENCY    = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [ADDR_W-1:0]  req_addr,
    output logic [1:0]         rsp_kind,
    output logic [31:0]        rsp_data,
    output logic [STALL_W-1:0] rsp_stall,
    output logic               nl_req,
    output logic [ADDR_W-1:0]  nl_addr,
    input  logic [1:0]         nl_kind,
    input  logic [31:0]        nl_data,
    input  logic [STALL_W-1:0] nl_stall
);
    localparam int WSEL_W = $clog2(LINE_WORDS);
    localparam int OFF_W  = WSEL_W + 2;
    localparam int IDX_W  = $clog2(SETS);
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;

    // request decode
    logic [TAG_W-1:0]  r_tag;
    logic [IDX_W-1:0]  r_idx;
    logic [WSEL_W-1:0] r_word;

    assign r_word = req_addr[2 +: WSEL_W];
    assign r_idx  = req_addr[OFF_W +: IDX_W];
    assign r_tag  = req_addr[ADDR_W-1 -: TAG_W];

    // per-set fill state
    logic [SETS-1:0]                              busy_vec;
    logic [SETS-1:0]                              ready_vec;
    logic [SETS-1:0]                              err_vec;
    logic [SETS-1:0]                              done_vec;
    logic [SETS-1:0]                              open_vec;
    logic [SETS-1:0]                              close_vec;
    logic [SETS-1:0]                              grant_vec;
    logic [SETS-1:0][STALL_W-1:0]                 cnt_vec;
    logic [SETS-1:0][ADDR_W-1:0]                  faddr_vec;
    logic [SETS-1:0][TAG_W-1:0]                   ftag_vec;
    logic [SETS-1:0][LINE_WORDS-1:0][WORD_W-1:0]  line_vec;

    logic              hit;
    logic [WORD_W-1:0] hit_data;
    logic [SETS-1:0]   valid_vec;
    logic              grant_any;
    logic [IDX_W-1:0]  grant_idx;

    // open a fill on a miss to an idle set; close an errored fill when read
    always_comb begin
        open_vec  = '0;
        close_vec = '0;
        if (req_valid && !hit) begin
            if (!busy_vec[r_idx]) open_vec[r_idx] = 1'b1;
            else if (err_vec[r_idx]) close_vec[r_idx] = 1'b1;
        end
    end

    for (genvar s = 0; s < SETS; s++) begin : g_fill
        dmc_set_fill #(
            .SET_ID     (s),
            .SETS       (SETS),
            .LINE_WORDS (LINE_WORDS),
            .ADDR_W     (ADDR_W),
            .STALL_W    (STALL_W),
            .LATENCY    (LATENCY)
        ) u_fill (
            .clk          (clk),
            .rst          (rst),
            .open_i       (open_vec[s]),
            .open_tag_i   (r_tag),
            .close_i      (close_vec[s]),
            .grant_i      (grant_vec[s]),
            .nl_kind_i    (nl_kind),
            .nl_data_i    (nl_data),
            .nl_stall_i   (nl_stall),
            .busy_o       (busy_vec[s]),
            .ready_o      (ready_vec[s]),
            .err_o        (err_vec[s]),
            .done_o       (done_vec[s]),
            .count_o      (cnt_vec[s]),
            .fetch_addr_o (faddr_vec[s]),
            .tag_o        (ftag_vec[s]),
            .line_o       (line_vec[s])
        );
    end

    dmc_fetch_arb #(
        .SETS (SETS)
    ) u_arb (
        .ready_i (ready_vec),
        .grant_o (grant_vec),
        .any_o   (grant_any),
        .idx_o   (grant_idx)
    );

    dmc_line_store #(
        .SETS       (SETS),
        .LINE_WORDS (LINE_WORDS),
        .TAG_W      (TAG_W)
    ) u_store (
        .clk       (clk),
        .rst       (rst),
        .wr_en_i   (|done_vec),
        .wr_idx_i  (grant_idx),
        .wr_tag_i  (ftag_vec[grant_idx]),
        .wr_line_i (line_vec[grant_idx]),
        .rd_idx_i  (r_idx),
        .rd_tag_i  (r_tag),
        .rd_word_i (r_word),
        .hit_o     (hit),
        .rd_data_o (hit_data),
        .valid_o   (valid_vec)
    );

    assign nl_req  = grant_any;
    assign nl_addr = faddr_vec[grant_idx];

    // requester response, same cycle
    always_comb begin
        rsp_kind  = RSP_MISS;
        rsp_data  = hit_data;
        rsp_stall = '0;
        if (req_valid) begin
            if (hit) begin
                rsp_kind = RSP_DATA;
            end else if (busy_vec[r_idx]) begin
                if (err_vec[r_idx]) rsp_kind = RSP_ERR;
                else                rsp_stall = cnt_vec[r_idx];
            end else begin
                rsp_stall = STALL_W'(LATENCY);
            end
        end
    end

endmodule

// File: rtl/dm_fill_cache_chk.sv
module dm_fill_cache_chk
    import dmc_pkg::*;
#(
    parameter int SETS       = 4,
    parameter int LINE_WORDS = 4,
    parameter int ADDR_W     = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic [1:0]        rsp_kind,
    input logic              nl_req,
    input logic [ADDR_W-1:0] nl_addr,
    input logic [SETS-1:0]   valid_vec,
    input logic [SETS-1:0]   busy_vec
);
    localparam int OFF_W = $clog2(LINE_WORDS) + 2;
    localparam int IDX_W = $clog2(SETS);

    logic [IDX_W-1:0] ridx;
    assign ridx = req_addr[OFF_W +: IDX_W];

    a_r11_reset_clears: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (valid_vec == '0 && busy_vec == '0));

    a_r2_hit_needs_valid: assert property (@(posedge clk) disable iff (rst)
        (req_valid && rsp_kind == RSP_DATA) |-> valid_vec[ridx]);

    a_r3_miss_opens_fill: assert property (@(posedge clk) disable iff (rst)
        (req_valid && rsp_kind == RSP_MISS && !busy_vec[ridx]) |=> busy_vec[$past(ridx)]);

    a_r7_error_from_open_fill: assert property (@(posedge clk) disable iff (rst)
        (req_valid && rsp_kind == RSP_ERR) |-> busy_vec[ridx]);

    a_r5_fetch_needs_fill: assert property (@(posedge clk) disable iff (rst)
        nl_req |-> (busy_vec != '0 && nl_addr[1:0] == 2'b00));

    for (genvar s = 0; s < SETS; s++) begin : g_set
        // R8: a line becomes valid only as its fill closes
        a_r8_valid_from_fill: assert property (@(posedge clk) disable iff (rst)
            (valid_vec[s] && !$past(valid_vec[s])) |-> ($past(busy_vec[s]) && !busy_vec[s]));
    end

endmodule

bind dm_fill_cache dm_fill_cache_chk #(
    .SETS       (SETS),
    .LINE_WORDS (LINE_WORDS),
    .ADDR_W     (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .rsp_kind  (rsp_kind),
    .nl_req    (nl_req),
    .nl_addr   (nl_addr),
    .valid_vec (valid_vec),
    .busy_vec  (busy_vec)
);

// File: tb/dm_fill_cache_test.sv
`timescale 1ns/1ps
module dm_fill_cache_test;
    localparam int SETS = 4, LW = 4, AW = 32, SW = 8, LAT = 3;
    localparam logic [1:0] K_DATA = 2'd0, K_MISS = 2'd1, K_ERR = 2'd2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [1:0] rsp_kind;
    logic [31:0] rsp_data;
    logic [SW-1:0] rsp_stall;
    logic nl_req;
    logic [AW-1:0] nl_addr;
    logic [1:0] nl_kind;
    logic [31:0] nl_data;
    logic [SW-1:0] nl_stall;

    always #2.5 clk = ~clk;

    dm_fill_cache #(.SETS(SETS), .LINE_WORDS(LW), .ADDR_W(AW), .STALL_W(SW), .LATENCY(LAT)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .rsp_kind(rsp_kind), .rsp_data(rsp_data), .rsp_stall(rsp_stall),
        .nl_req(nl_req), .nl_addr(nl_addr), .nl_kind(nl_kind), .nl_data(nl_data), .nl_stall(nl_stall));

    int n_tests = 0, n_fail = 0;
    int cyc_no = 0;
    logic inj_armed = 1'b0;
    logic [AW-1:0] inj_addr = '0;
    logic [SW-1:0] inj_n = '0;
    logic [AW-1:0] log_addr [0:31];
    logic [1:0]    log_kind [0:31];
    int            log_cyc  [0:31];
    int            log_n = 0;
    logic [SW-1:0] stall_hist [0:255];

    function automatic logic [31:0] mem_word(input logic [AW-1:0] a);
        logic [AW-1:0] w;
        w = {a[AW-1:2], 2'b00};
        return {~w[15:0], w[15:0]} ^ {w[31:16], 16'h0};
    endfunction

    // next-level memory model: addresses with the top bit set are invalid
    always_comb begin
        nl_kind  = K_DATA;
        nl_data  = mem_word(nl_addr);
        nl_stall = '0;
        if (nl_addr[AW-1]) begin
            nl_kind = K_ERR;
        end else if (inj_armed && nl_addr == inj_addr) begin
            nl_kind  = K_MISS;
            nl_stall = inj_n;
        end
    end

    always @(posedge clk) begin
        if (nl_req) begin
            if (log_n < 32) begin
                log_addr[log_n] = nl_addr;
                log_kind[log_n] = nl_kind;
                log_cyc[log_n]  = cyc_no;
            end
            log_n = log_n + 1;
            if (inj_armed && nl_addr == inj_addr && !nl_addr[AW-1]) inj_armed <= 1'b0;
        end
        cyc_no = cyc_no + 1;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic probe(input logic [AW-1:0] a, output logic [1:0] k,
                         output logic [31:0] d, output logic [SW-1:0] st, output int at);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        #1;
        k  = rsp_kind;
        d  = rsp_data;
        st = rsp_stall;
        at = cyc_no;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
        end
    endtask

    // reads until the answer is not MISS; misses = number of MISS answers
    task automatic poll(input logic [AW-1:0] a, output int misses, output logic [1:0] k,
                        output logic [31:0] d, output int start);
        logic [SW-1:0] st;
        int at;
        misses = 0;
        probe(a, k, d, st, start);
        stall_hist[0] = st;
        while (k == K_MISS && misses < 250) begin
            misses++;
            probe(a, k, d, st, at);
            stall_hist[misses] = st;
        end
    endtask

    task automatic clr_log();
        @(negedge clk);
        log_n = 0;
    endtask

    initial begin
        #(5.0 * 150000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int misses, start, at;
        logic [1:0] k;
        logic [31:0] d;
        logic [SW-1:0] st;
        logic [AW-1:0] a;
        bit ok;
        int unsigned seed_val;

        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // T1: first read after reset, plain fill, hit timing
        clr_log();
        poll(32'h0000_0044, misses, k, d, start);
        chk(stall_hist[0] == SW'(LAT), "R11", "stall after reset", stall_hist[0], LAT);
        chk(stall_hist[1] == SW'(LAT), "R9", "remaining stall", stall_hist[1], LAT);
        chk(stall_hist[2] == SW'(LAT-1), "R4", "countdown step", stall_hist[2], LAT-1);
        chk(misses == LAT + LW + 1, "R8", "cycles to hit", misses, LAT + LW + 1);
        chk(k == K_DATA && d == mem_word(32'h44), "R2", "hit data", d, mem_word(32'h44));
        chk(log_cyc[0] - start == LAT + 1, "R3", "first request delay", log_cyc[0] - start, LAT + 1);
        ok = (log_n == LW);
        for (int i = 0; i < LW; i++) if (log_addr[i] != 32'h40 + 4 * i) ok = 0;
        chk(ok, "R5", "word order", log_n, LW);
        for (int i = 0; i < 4; i++) begin
            a = 32'h40 + 4 * i + i;
            probe(a, k, d, st, at);
            chk(k == K_DATA && d == mem_word(a), "R1", "word select", d, mem_word(a));
        end

        // T2: next-level stall on the third word of set 1
        clr_log();
        inj_addr  = 32'h58;
        inj_n     = 8'd4;
        inj_armed = 1'b1;
        poll(32'h0000_0050, misses, k, d, start);
        chk(misses == LAT + LW + 1 + 5, "R6", "cycles with stall", misses, LAT + LW + 6);
        chk(stall_hist[7] == 8'd4, "R9", "reloaded stall", stall_hist[7], 4);
        ok = (log_n == LW + 1) && log_kind[2] == K_MISS && log_addr[2] == 32'h58
             && log_addr[3] == 32'h58 && log_addr[4] == 32'h5C && log_addr[1] == 32'h54;
        chk(ok, "R6", "resume without refetch", log_n, LW + 1);
        chk(k == K_DATA && d == mem_word(32'h50), "R6", "data after stall", d, mem_word(32'h50));

        // T3: invalid address error in set 2
        poll(32'h8000_0020, misses, k, d, start);
        chk(k == K_ERR, "R7", "error kind", k, K_ERR);
        chk(misses == LAT + 2, "R7", "error timing", misses, LAT + 2);
        probe(32'h8000_0020, k, d, st, at);
        chk(k == K_MISS && st == SW'(LAT), "R7", "error closes fill", st, LAT);
        poll(32'h8000_0020, misses, k, d, start);
        probe(32'h0000_0020, k, d, st, at);
        chk(k == K_MISS && st == SW'(LAT), "R7", "fresh fill after error", st, LAT);
        poll(32'h0000_0020, misses, k, d, start);

        // T4: two tags competing for set 0
        clr_log();
        probe(32'h0000_00C0, k, d, st, at);
        probe(32'h0000_0100, k, d, st, at);
        chk(k == K_MISS && st == SW'(LAT), "R10", "second tag waits", st, LAT);
        poll(32'h0000_00C4, misses, k, d, start);
        ok = (log_n == LW);
        for (int i = 0; i < LW; i++) if (log_addr[i][AW-1:4] != 28'h00C) ok = 0;
        chk(ok, "R10", "only one line fetched", log_n, LW);
        probe(32'h0000_0100, k, d, st, at);
        chk(k == K_MISS && st == SW'(LAT), "R2", "tag mismatch misses", k, K_MISS);
        poll(32'h0000_0100, misses, k, d, start);
        chk(k == K_DATA && d == mem_word(32'h100), "R2", "second tag data", d, mem_word(32'h100));

        // T5: set 3 starts first, set 2 takes over the port
        idle(2);
        clr_log();
        probe(32'h0000_00F0, k, d, st, at);
        probe(32'h0000_00E0, k, d, st, at);
        idle(14);
        ok = (log_n == 2 * LW) && log_addr[0] == 32'hF0;
        for (int i = 0; i < LW; i++) if (log_addr[1 + i] != 32'hE0 + 4 * i) ok = 0;
        for (int i = 1; i < LW; i++) if (log_addr[LW + i] != 32'hF0 + 4 * i) ok = 0;
        chk(ok, "R12", "priority order", log_n, 2 * LW);
        ok = 1;
        for (int i = 1; i < log_n && i < 32; i++) if (log_cyc[i] == log_cyc[i-1]) ok = 0;
        chk(ok, "R12", "one request per cycle", log_n, 2 * LW);
        probe(32'h0000_00F8, k, d, st, at);
        chk(k == K_DATA && d == mem_word(32'hF8), "R12", "preempted line data", d, mem_word(32'hF8));

        // T6: reset with valid lines
        @(negedge clk);
        rst = 1'b1;
        req_valid = 1'b0;
        idle(2);
        rst = 1'b0;
        probe(32'h0000_0040, k, d, st, at);
        chk(k == K_MISS && st == SW'(LAT), "R11", "reset invalidates", k, K_MISS);
        poll(32'h0000_0040, misses, k, d, start);

        // T7: random reads with random next-level stalls
        seed_val = $urandom(32'd2024);
        for (int n = 0; n < 300; n++) begin
            a = {26'($urandom % 6), 2'($urandom), 2'($urandom), 2'($urandom)};
            @(negedge clk);
            inj_armed = 1'b0;
            if ($urandom % 3 == 0) begin
                inj_addr  = {a[AW-1:4], 2'($urandom), 2'b00};
                inj_n     = SW'($urandom % 7);
                inj_armed = 1'b1;
            end
            poll(a, misses, k, d, start);
            chk(k == K_DATA && d == mem_word(a), "R5", "random read", d, mem_word(a));
        end

        idle(2);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule